// File: doc/BRIEF.md
# Programmable Limit Interval Timer

This block is a single up-counting interval timer with a small register port. A counter advances by one on every enabled clock cycle until it equals a programmed limit, then returns to zero on the following cycle. Each limit match marks an interrupt as pending, and the interrupt output is asserted while the pending flag is set and interrupts are enabled. Software clears the pending flag by writing the control register. A control bit can make the counter pause while an external processor-halt input is high.

Software arms a one-shot by writing the limit register and then writing zero to the count register. Periodic operation follows from the automatic return to zero. The pending flag is tracked by a two-state machine. PEND_IDLE moves to PEND_SET on the RAISE transition, which is a limit match. PEND_SET moves back to PEND_IDLE on the ACK transition, which is a control write in a cycle with no match. In every other case each state holds, and that includes a match that arrives while already in PEND_SET.

Register selects are COUNT = 2'd0, LIMIT = 2'd1, CTRL = 2'd2, and 2'd3 is unused. CTRL reads back as {zeros, pending (bit 3), 0 (bit 2), halt-gate (bit 1), irq-enable (bit 0)}.

Top module: `lim_timer`

## Requirements
- R1: After reset, COUNT reads 0, LIMIT reads all ones, CTRL reads 0 and irq is low.
- R2: On an enabled cycle with no COUNT write, COUNT advances by 1, or becomes 0 on the next cycle if it equals LIMIT.
- R3: When CTRL bit 1 (halt-gate) is 1 and halted is high, COUNT holds. When bit 1 is 0, the halted input has no effect on counting.
- R4: A limit match sets the pending flag (CTRL bit 3) whether or not CTRL bit 0 is set.
- R5: irq is high exactly when CTRL bit 0 (irq-enable) and CTRL bit 3 (pending) are both 1.
- R6: Any CTRL write loads bit 0 and bit 1 from wr_data, ignores every other data bit and clears the pending flag. CTRL reads back as {zeros, pending, 0, halt-gate, irq-enable}.
- R7: When a limit match and a CTRL write fall in the same cycle, the pending flag is set after that cycle.
- R8: A COUNT write loads wr_data and takes priority over advancing. No limit match happens in that cycle.
- R9: A LIMIT write leaves COUNT unchanged. If the new LIMIT is below COUNT, the counter runs through the all-ones value, wraps to 0 and only then can match.
- R10: Select 2'd3 reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| halted | input | 1 | Processor-halt indication |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | W | Read data for rd_sel |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted counter value shows on the COUNT read in the same cycle. It also moves the limit match, so the pending flag and irq appear early, appear late or never appear. A stuck or wrongly sequenced pending state machine shows at the next CTRL read and on irq in the cycle right after the missed RAISE or ACK. The bench therefore compares COUNT, CTRL and irq against a cycle model after every clock edge, so any divergence is reported in the cycle where it happens.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PEND_IDLE = 1'b0,
        PEND_SET  = 1'b1
    } pend_state_e;

    localparam int CTRL_IE_BIT = 0;
    localparam int CTRL_NH_BIT = 1;
    localparam int CTRL_IP_BIT = 3;
    localparam int CTRL_USED   = CTRL_IP_BIT + 1;

endpackage

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         hit
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // a load supersedes the advance, so no match in that cycle (R8)
    assign hit = advance && !load && (count == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (advance) begin
            // natural overflow at all ones gives the wrap of R9
            count <= hit ? '0 : count + ONE;
        end
    end

endmodule

// File: rtl/ltmr_cfg.sv
module ltmr_cfg import ltmr_pkg::*; #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lim_we,
    input  logic         ctrl_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] limit,
    output logic         ie,
    output logic         nh
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= '1;
        end else if (lim_we) begin
            limit <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= 1'b0;
            nh <= 1'b0;
        end else if (ctrl_we) begin
            ie <= wdata[CTRL_IE_BIT];
            nh <= wdata[CTRL_NH_BIT];
        end
    end

endmodule

// File: rtl/ltmr_pend_fsm.sv
module ltmr_pend_fsm import ltmr_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    input  logic ie,
    output logic pending,
    output logic irq
);

    pend_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PEND_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: begin
                if (hit) state_d = PEND_SET;          // RAISE
            end
            PEND_SET: begin
                if (ack && !hit) state_d = PEND_IDLE; // ACK, a match wins
            end
        endcase
    end

    always_comb begin
        pending = (state_q == PEND_SET);
        irq     = (state_q == PEND_SET) && ie;
    end

endmodule

// File: rtl/lim_timer.sv
module lim_timer import ltmr_pkg::*; #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         halted,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         irq
);

    localparam int CTRL_PAD = W - CTRL_USED;

    logic         cnt_we, lim_we, ctrl_we;
    logic         adv;
    logic         hit;
    logic [W-1:0] count_val, limit_val;
    logic         ie_val, nh_val, ip_val;
    logic [W-1:0] ctrl_word;

    assign cnt_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
    assign lim_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_LIMIT);
    assign ctrl_we = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    assign adv     = !(nh_val && halted);

    ltmr_cfg #(.W(W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lim_we  (lim_we),
        .ctrl_we (ctrl_we),
        .wdata   (wr_data),
        .limit   (limit_val),
        .ie      (ie_val),
        .nh      (nh_val)
    );

    ltmr_counter #(.W(W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_we),
        .load_val (wr_data),
        .advance  (adv),
        .limit    (limit_val),
        .count    (count_val),
        .hit      (hit)
    );

    ltmr_pend_fsm pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .ack     (ctrl_we),
        .ie      (ie_val),
        .pending (ip_val),
        .irq     (irq)
    );

    assign ctrl_word = {{CTRL_PAD{1'b0}}, ip_val, 1'b0, nh_val, ie_val};

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_COUNT: rd_data = count_val;
            SEL_LIMIT: rd_data = limit_val;
            SEL_CTRL:  rd_data = ctrl_word;
            SEL_NONE:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         halted,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic         wd_ie,
    input logic         irq,
    input logic [W-1:0] count_val,
    input logic [W-1:0] limit_val,
    input logic         nh_val,
    input logic         ip_val
);

    logic c_cnt_w, c_lim_w, c_ctl_w, c_adv, c_match;

    always_comb begin
        c_cnt_w = wr_en && (wr_sel == 2'd0);
        c_lim_w = wr_en && (wr_sel == 2'd1);
        c_ctl_w = wr_en && (wr_sel == 2'd2);
        c_adv   = !(nh_val && halted);
        c_match = c_adv && !c_cnt_w && (count_val == limit_val);
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_match |=> (count_val == '0));

    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nh_val && halted && !c_cnt_w) |=> $stable(count_val));

    assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_match |=> ip_val);

    assert_irq_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctl_w && !wd_ie) |=> !irq);

    assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctl_w && !c_match) |=> !ip_val);

    assert_race_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctl_w && c_match) |=> ip_val);

    assert_limit_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_lim_w && !c_adv) |=> $stable(count_val));

endmodule

bind lim_timer lim_timer_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted    (halted),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wd_ie     (wr_data[0]),
    .irq       (irq),
    .count_val (count_val),
    .limit_val (limit_val),
    .nh_val    (nh_val),
    .ip_val    (ip_val)
);

// File: tb/lim_timer_tb.sv
module lim_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         halted = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_sel = 2'd0;
    logic [W-1:0] rd_data;
    logic         irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [W-1:0] m_cnt, m_lim;
    logic         m_ie, m_nh, m_ip;

    always #(CLK_PERIOD/2) clk = ~clk;

    lim_timer #(.W(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .halted  (halted),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic logic [W-1:0] exp_ctrl();
        return {{(W-4){1'b0}}, m_ip, 1'b0, m_nh, m_ie};
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // reads every register through the port and compares with the model
    task automatic check_all(string tag);
        rd_sel = 2'd0; #1;
        check(tag, "COUNT", rd_data, m_cnt);
        rd_sel = 2'd1; #1;
        check(tag, "LIMIT", rd_data, m_lim);
        rd_sel = 2'd2; #1;
        check(tag, "CTRL", rd_data, exp_ctrl());
        check(tag, "irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_ie & m_ip});
    endtask

    // called just after a falling edge; ends after the next falling edge
    task automatic do_cycle(string tag, logic we, logic [1:0] sel, logic [W-1:0] d, logic hlt);
        logic adv, cw, lw, kw, hit;
        logic [W-1:0] n_cnt, n_lim;
        logic n_ie, n_nh, n_ip;
        wr_en = we; wr_sel = sel; wr_data = d; halted = hlt;
        adv = !(m_nh && hlt);
        cw = we && sel == 2'd0;
        lw = we && sel == 2'd1;
        kw = we && sel == 2'd2;
        hit = adv && !cw && (m_cnt == m_lim);
        n_cnt = cw ? d : (adv ? (hit ? '0 : m_cnt + 1) : m_cnt);
        n_lim = lw ? d : m_lim;
        n_ie = kw ? d[0] : m_ie;
        n_nh = kw ? d[1] : m_nh;
        n_ip = hit ? 1'b1 : (kw ? 1'b0 : m_ip);
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_cnt = n_cnt; m_lim = n_lim; m_ie = n_ie; m_nh = n_nh; m_ip = n_ip;
        check_all(tag);
        @(negedge clk);
    endtask

    task automatic idle(string tag, int n, logic hlt);
        for (int i = 0; i < n; i++) do_cycle(tag, 1'b0, 2'd0, '0, hlt);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_cnt = '0; m_lim = '1; m_ie = 1'b0; m_nh = 1'b0; m_ip = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
        rd_sel = 2'd3; #1;
        check("R10", "SEL3 read", rd_data, '0);

        // one-shot with irq disabled first: pending still sets (R4)
        do_cycle("R9", 1'b1, 2'd1, 32'd5, 1'b0);
        do_cycle("R8", 1'b1, 2'd0, 32'd0, 1'b0);
        idle("R4", 7, 1'b0);
        do_cycle("R5", 1'b1, 2'd2, 32'd1, 1'b0); // ack and enable
        do_cycle("R8", 1'b1, 2'd0, 32'd0, 1'b0);
        idle("R5", 7, 1'b0);
        // CTRL write with all data bits set: only bits 0 and 1 land (R6)
        do_cycle("R6", 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0);
        // halt gating (R3)
        idle("R3", 3, 1'b1);
        idle("R3", 2, 1'b0);
        do_cycle("R3", 1'b1, 2'd2, 32'd1, 1'b1);
        idle("R3", 3, 1'b1);
        // match and CTRL write in one cycle (R7)
        do_cycle("R7", 1'b1, 2'd1, 32'd2, 1'b0);
        do_cycle("R7", 1'b1, 2'd0, 32'd0, 1'b0);
        idle("R7", 2, 1'b0);
        do_cycle("R7", 1'b1, 2'd2, 32'd1, 1'b0);
        // COUNT write on a match cycle: no match (R8)
        do_cycle("R8", 1'b1, 2'd2, 32'd0, 1'b0);
        do_cycle("R8", 1'b1, 2'd0, 32'd2, 1'b0);
        do_cycle("R8", 1'b1, 2'd0, 32'd7, 1'b0);
        // LIMIT below COUNT: wrap through all ones (R9)
        do_cycle("R9", 1'b1, 2'd0, 32'hFFFF_FFFD, 1'b0);
        do_cycle("R9", 1'b1, 2'd1, 32'd3, 1'b0);
        idle("R9", 8, 1'b0);
        // unused select write (R10)
        do_cycle("R10", 1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0);

        // constrained random mix (R2 and all others by the model)
        for (int i = 0; i < 4000; i++) begin
            logic we;
            logic [1:0] sel;
            logic [W-1:0] d;
            we = ($urandom % 5) == 0;
            sel = 2'($urandom % 4);
            d = (sel == 2'd2) ? 32'($urandom % 16) : 32'($urandom % 24);
            do_cycle("R2", we, sel, d, 1'($urandom % 3 == 0));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule